// File: doc/BRIEF.md
# UART DMA Ready Handshake Generator

This block produces the two active-low DMA request strobes of one UART channel: a transmit-side "room available" signal and a receive-side "data available" signal. It does not hold data. It watches the fill counts of the channel's transmit and receive FIFOs, the trigger thresholds set by software, and a one-cycle receive timeout event. From these it decides when a DMA controller should move data.

Two handshake styles are supported. In single-transfer style, each strobe follows the simple empty or non-empty state of its buffer. In block-transfer style, each strobe has hysteresis. The transmit strobe stays asserted until the FIFO is completely full, and re-asserts only once the fill drops below the transmit threshold. The receive strobe asserts at the receive threshold, or on a timeout while data is waiting, and stays asserted until the FIFO has drained to empty. When the FIFOs are switched off, the block always uses single-transfer style, and each count is then the occupancy (0 or 1) of a holding register. Both outputs are registered, so they reflect the inputs one clock later.

Top module: `uart_dma_ready`

## Requirements
- R1: While reset is active, and in the first cycle after it, the transmit strobe `tx_rdy_n` is 0 and the receive strobe `rx_rdy_n` is 1.
- R2: In single-transfer style, `tx_rdy_n` is 1 one clock after `tx_level` is non-zero, and 0 one clock after `tx_level` is zero.
- R3: In single-transfer style, `rx_rdy_n` is 0 one clock after `rx_level` is non-zero, and 1 one clock after `rx_level` is zero.
- R4: In block-transfer style, `tx_rdy_n` becomes 1 one clock after `tx_level` equals the parameter `DEPTH`.
- R5: In block-transfer style, `tx_rdy_n` becomes 0 one clock after `tx_level` is below `tx_trig`. For a level from `tx_trig` up to `DEPTH-1`, it keeps its previous value.
- R6: In block-transfer style, `rx_rdy_n` becomes 0 one clock after `rx_level` is at or above `rx_trig`.
- R7: In block-transfer style, a 1 on `rx_tmo` with `rx_level` non-zero drives `rx_rdy_n` to 0 on the next clock. A 1 on `rx_tmo` with `rx_level` zero leaves `rx_rdy_n` at 1.
- R8: In block-transfer style, `rx_rdy_n` returns to 1 one clock after `rx_level` is zero. For a non-zero level below `rx_trig` with no timeout, it keeps its previous value.
- R9: Block-transfer style is in effect only when `fifo_en` is 1 and `dma_blk` is 1. With `fifo_en` at 0, the outputs follow R2 and R3 whatever `dma_blk` is.
- R10: Leaving block-transfer style discards its hysteresis. On re-entry, the outputs are judged afresh from the current levels: `tx_rdy_n` is 1 only if the transmit FIFO is full, and `rx_rdy_n` is 0 only if the receive level is at or above `rx_trig`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | 1 = FIFOs enabled, 0 = single holding registers |
| dma_blk | input | 1 | 1 = request block-transfer style |
| tx_level | input | $clog2(DEPTH+1) | Characters in the transmit FIFO or holding register |
| rx_level | input | $clog2(DEPTH+1) | Characters in the receive FIFO or holding register |
| tx_trig | input | $clog2(DEPTH+1) | Transmit threshold, 1 to DEPTH (software resets it to DEPTH/2) |
| rx_trig | input | $clog2(DEPTH+1) | Receive threshold, 1 to DEPTH |
| rx_tmo | input | 1 | One-cycle receive timeout event |
| tx_rdy_n | output | 1 | Transmit DMA strobe, active low |
| rx_rdy_n | output | 1 | Receive DMA strobe, active low |

## Verification
The hardest state to reach is a fill level that sits between its threshold and its clearing point. There the output must be decided by history and not by the current count. Which history applies also depends on whether block-transfer style was left and re-entered.

The stimulus reaches this state on purpose. It first pushes a level to full, or to the threshold, and then moves it into the band. Next it toggles `dma_blk` and `fifo_en` while the level is parked in the band, to show that the hysteresis is dropped. Timeout pulses are sent both with data present and with the receive FIFO empty. A long random phase then mixes mode, level, threshold and timeout changes. It is compared against a behavioural model on every clock.

// File: rtl/uart_dma_ready_pkg.sv
// Package: shared types and helpers for the DMA ready generator.
// Assumes levels and thresholds share one unsigned width.
package uart_dma_ready_pkg;

    // Handshake style in effect for a channel
    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BLOCK  = 1'b1
    } xfer_mode_e;

    // Resolve the effective style: block transfers need FIFOs on
    function automatic xfer_mode_e resolve_mode(input logic fifo_on, input logic blk_req);
        return (fifo_on && blk_req) ? XFER_BLOCK : XFER_SINGLE;
    endfunction

endpackage

// File: rtl/uart_dma_mode_sel.sv
// Module: uart_dma_mode_sel
// Turns the FIFO enable and the block-transfer request into the effective
// handshake style. It is purely combinational. The trackers register the
// result, so a style change is seen at the outputs one clock later.
module uart_dma_mode_sel
    import uart_dma_ready_pkg::*;
(
    input  logic       fifo_en,
    input  logic       dma_blk,
    output xfer_mode_e mode
);

    // Effective style decode
    always_comb begin
        mode = resolve_mode(fifo_en, dma_blk);
    end

endmodule

// File: rtl/uart_dma_tx_track.sv
// Module: uart_dma_tx_track
// Builds the transmit DMA strobe (active low).
// Single style: the strobe is high while anything is queued.
// Block style: a busy flag is set when the FIFO is full and cleared
// when the fill drops below the threshold; the strobe follows that flag.
// Assumes 1 <= thr <= DEPTH. The busy flag is cleared whenever single
// style is in effect, so each entry into block style starts fresh.
module uart_dma_tx_track
    import uart_dma_ready_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_mode_e    mode,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] thr,
    output logic          rdy_n
);

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic busy_q;
    logic busy_d;
    logic rdy_n_d;

    // Next busy flag: full sets it, dropping below threshold clears it
    always_comb begin
        busy_d = busy_q;
        if (mode == XFER_SINGLE) begin
            busy_d = 1'b0;
        end else if (level == FULL_LVL) begin
            busy_d = 1'b1;
        end else if (level < thr) begin
            busy_d = 1'b0;
        end
    end

    // Next strobe level for the active style
    always_comb begin
        if (mode == XFER_BLOCK) begin
            rdy_n_d = busy_d;
        end else begin
            rdy_n_d = (level != '0);
        end
    end

    // Hold the flag and the strobe; reset means nothing queued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rdy_n  <= 1'b0;
        end else begin
            busy_q <= busy_d;
            rdy_n  <= rdy_n_d;
        end
    end

endmodule

// File: rtl/uart_dma_rx_track.sv
// Module: uart_dma_rx_track
// Builds the receive DMA strobe (active low).
// Single style: the strobe is low while any character waits.
// Block style: a ready flag is set when the fill reaches the threshold,
// or when a timeout arrives with data waiting. It is cleared only when
// the FIFO is empty, and emptiness takes priority over both set causes.
// Assumes 1 <= thr <= DEPTH and a timeout that lasts one cycle.
module uart_dma_rx_track
    import uart_dma_ready_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_mode_e    mode,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] thr,
    input  logic          tmo,
    output logic          rdy_n
);

    logic avail_q;
    logic avail_d;
    logic rdy_n_d;

    // Next ready flag: an empty FIFO clears it, threshold or timeout sets it
    always_comb begin
        avail_d = avail_q;
        if (mode == XFER_SINGLE) begin
            avail_d = 1'b0;
        end else if (level == '0) begin
            avail_d = 1'b0;
        end else if ((level >= thr) || tmo) begin
            avail_d = 1'b1;
        end
    end

    // Next strobe level for the active style
    always_comb begin
        if (mode == XFER_BLOCK) begin
            rdy_n_d = !avail_d;
        end else begin
            rdy_n_d = (level == '0);
        end
    end

    // Hold the flag and the strobe; reset means no data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail_q <= 1'b0;
            rdy_n   <= 1'b1;
        end else begin
            avail_q <= avail_d;
            rdy_n   <= rdy_n_d;
        end
    end

endmodule

// File: rtl/uart_dma_ready.sv
// Module: uart_dma_ready (top)
// DMA ready strobe generator for one UART channel. It observes FIFO
// counts, thresholds and the receive timeout, and drives the registered,
// active-low transmit and receive strobes in single or block style.
// Assumes that with FIFOs off each level is 0 or 1, and that the
// thresholds lie between 1 and DEPTH.
module uart_dma_ready
    import uart_dma_ready_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          dma_blk,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] tx_trig,
    input  logic [LW-1:0] rx_trig,
    input  logic          rx_tmo,
    output logic          tx_rdy_n,
    output logic          rx_rdy_n
);

    xfer_mode_e mode;

    uart_dma_mode_sel u_mode (
        .fifo_en (fifo_en),
        .dma_blk (dma_blk),
        .mode    (mode)
    );

    uart_dma_tx_track #(.DEPTH(DEPTH)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .level (tx_level),
        .thr   (tx_trig),
        .rdy_n (tx_rdy_n)
    );

    uart_dma_rx_track #(.DEPTH(DEPTH)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .level (rx_level),
        .thr   (rx_trig),
        .tmo   (rx_tmo),
        .rdy_n (rx_rdy_n)
    );

endmodule

// File: rtl/uart_dma_ready_chk.sv
// Module: uart_dma_ready_chk
// Checker bound to uart_dma_ready. It relates the registered strobes to
// the port values of the previous clock.
module uart_dma_ready_chk #(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          dma_blk,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic [LW-1:0] tx_trig,
    input logic [LW-1:0] rx_trig,
    input logic          rx_tmo,
    input logic          tx_rdy_n,
    input logic          rx_rdy_n
);

    logic blk;
    assign blk = fifo_en && dma_blk;

    // R1: reset values are visible right after release
    p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!tx_rdy_n && rx_rdy_n));

    // R2: single-style transmit strobe follows occupancy
    p_single_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(blk)) |-> (tx_rdy_n == ($past(tx_level) != 0)));

    // R3: single-style receive strobe follows occupancy
    p_single_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(blk)) |-> (rx_rdy_n == ($past(rx_level) == 0)));

    // R4: a full FIFO deasserts the block-style transmit strobe
    p_blk_tx_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blk) && $past(tx_level) == LW'(DEPTH)) |-> tx_rdy_n);

    // R5: below the threshold the block-style transmit strobe is asserted
    p_blk_tx_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blk) && ($past(tx_level) < $past(tx_trig))) |-> !tx_rdy_n);

    // R6: reaching the threshold asserts the block-style receive strobe
    p_blk_rx_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blk) && $past(rx_level) != 0 &&
         ($past(rx_level) >= $past(rx_trig))) |-> !rx_rdy_n);

    // R7: a timeout with data waiting asserts the block-style receive strobe
    p_blk_rx_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blk) && $past(rx_tmo) && $past(rx_level) != 0) |-> !rx_rdy_n);

    // R8: an empty FIFO deasserts the block-style receive strobe
    p_blk_rx_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blk) && $past(rx_level) == 0) |-> rx_rdy_n);

    // R9: FIFOs off means single style whatever the request bit says
    p_fifo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fifo_en)) |->
        (tx_rdy_n == ($past(tx_level) != 0) && rx_rdy_n == ($past(rx_level) == 0)));

endmodule

bind uart_dma_ready uart_dma_ready_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .dma_blk  (dma_blk),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_trig  (tx_trig),
    .rx_trig  (rx_trig),
    .rx_tmo   (rx_tmo),
    .tx_rdy_n (tx_rdy_n),
    .rx_rdy_n (rx_rdy_n)
);

// File: tb/uart_dma_ready_tb_top.sv
// Bench for uart_dma_ready: directed scenarios plus a random phase,
// checked against a behavioural model on every clock.
module uart_dma_ready_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int LW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fifo_en;
    logic          dma_blk;
    logic [LW-1:0] tx_level;
    logic [LW-1:0] rx_level;
    logic [LW-1:0] tx_trig;
    logic [LW-1:0] rx_trig;
    logic          rx_tmo;
    logic          tx_rdy_n;
    logic          rx_rdy_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    bit m_tx_n, m_rx_n, m_tx_hold, m_rx_hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_dma_ready #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_blk(dma_blk),
        .tx_level(tx_level), .rx_level(rx_level), .tx_trig(tx_trig),
        .rx_trig(rx_trig), .rx_tmo(rx_tmo), .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n)
    );

    // Reference model: updated from the inputs present at each rising edge
    always @(posedge clk) begin
        int txl, rxl, txt, rxt;
        txl = int'(tx_level); rxl = int'(rx_level);
        txt = int'(tx_trig);  rxt = int'(rx_trig);
        if (!rst_n) begin
            m_tx_hold = 0; m_rx_hold = 0; m_tx_n = 0; m_rx_n = 1;
        end else if (fifo_en && dma_blk) begin
            if (txl == DEPTH) m_tx_hold = 1;
            else if (txl < txt) m_tx_hold = 0;
            if (rxl == 0) m_rx_hold = 0;
            else if (rxl >= rxt || rx_tmo) m_rx_hold = 1;
            m_tx_n = m_tx_hold;
            m_rx_n = !m_rx_hold;
        end else begin
            m_tx_hold = 0; m_rx_hold = 0;
            m_tx_n = (txl != 0);
            m_rx_n = (rxl == 0);
        end
    end

    // Compare with the model on every falling edge
    always @(negedge clk) begin
        if (rst_n !== 1'bx) begin
            checks++;
            if (tx_rdy_n !== m_tx_n || rx_rdy_n !== m_rx_n) begin
                errors++;
                $display("FAIL MODEL t=%0t: tx_rdy_n/rx_rdy_n actual %b%b expected %b%b",
                         $time, tx_rdy_n, rx_rdy_n, m_tx_n, m_rx_n);
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Apply values just after a falling edge, then wait one edge so the result shows
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL WATCHDOG: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fifo_en = 1; dma_blk = 0; tx_level = 0; rx_level = 0;
        tx_trig = LW'(16); rx_trig = LW'(8); rx_tmo = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 tx reset", tx_rdy_n, 1'b0);
        check("R1 rx reset", rx_rdy_n, 1'b1);
        rst_n = 1;
        tick();
        check("R1 tx after release", tx_rdy_n, 1'b0);
        check("R1 rx after release", rx_rdy_n, 1'b1);

        // single style
        tx_level = 1; tick(); check("R2 tx one char", tx_rdy_n, 1'b1);
        tx_level = 0; tick(); check("R2 tx empty", tx_rdy_n, 1'b0);
        rx_level = 3; tick(); check("R3 rx data", rx_rdy_n, 1'b0);
        rx_level = 0; tick(); check("R3 rx empty", rx_rdy_n, 1'b1);

        // enter block style with levels inside the bands
        tx_level = 20; rx_level = 5; dma_blk = 1; tick();
        check("R10 tx fresh entry", tx_rdy_n, 1'b0);
        check("R10 rx fresh entry", rx_rdy_n, 1'b1);
        tx_level = LW'(DEPTH); tick(); check("R4 tx full", tx_rdy_n, 1'b1);
        tx_level = 20; tick(); check("R5 tx hold in band", tx_rdy_n, 1'b1);
        tx_level = 15; tick(); check("R5 tx below trig", tx_rdy_n, 1'b0);
        tx_level = 20; tick(); check("R5 tx hold low in band", tx_rdy_n, 1'b0);
        rx_level = 8; tick(); check("R6 rx at trig", rx_rdy_n, 1'b0);
        rx_level = 3; tick(); check("R8 rx hold in band", rx_rdy_n, 1'b0);
        rx_level = 0; tick(); check("R8 rx empty", rx_rdy_n, 1'b1);
        rx_level = 2; rx_tmo = 1; tick(); rx_tmo = 0;
        check("R7 rx timeout with data", rx_rdy_n, 1'b0);
        tick(); check("R7 rx stays after timeout", rx_rdy_n, 1'b0);
        rx_level = 0; tick();
        rx_tmo = 1; tick(); rx_tmo = 0;
        check("R7 rx timeout when empty", rx_rdy_n, 1'b1);

        // leave and re-enter block style with levels parked in the band
        tx_level = LW'(DEPTH); rx_level = 10; tick();
        check("R4 tx full again", tx_rdy_n, 1'b1);
        dma_blk = 0; tx_level = 20; rx_level = 5; tick();
        check("R2 tx in band single", tx_rdy_n, 1'b1);
        dma_blk = 1; tick();
        check("R10 tx re-entry drops hold", tx_rdy_n, 1'b0);
        check("R10 rx re-entry drops hold", rx_rdy_n, 1'b1);

        // FIFOs off overrides the request bit
        fifo_en = 0; tx_level = 1; rx_level = 1; tick();
        check("R9 tx fifo off", tx_rdy_n, 1'b1);
        check("R9 rx fifo off", rx_rdy_n, 1'b0);
        tx_level = 0; rx_level = 0; tick();
        check("R9 tx fifo off empty", tx_rdy_n, 1'b0);
        check("R9 rx fifo off empty", rx_rdy_n, 1'b1);

        // random phase, checked by the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            if ($urandom_range(0, 15) == 0) fifo_en = $urandom_range(0, 1);
            if ($urandom_range(0, 15) == 0) dma_blk = $urandom_range(0, 1);
            if ($urandom_range(0, 31) == 0) tx_trig = LW'($urandom_range(1, DEPTH));
            if ($urandom_range(0, 31) == 0) rx_trig = LW'($urandom_range(1, DEPTH));
            if (fifo_en) begin
                tx_level = LW'($urandom_range(0, DEPTH));
                rx_level = LW'($urandom_range(0, DEPTH));
            end else begin
                tx_level = LW'($urandom_range(0, 1));
                rx_level = LW'($urandom_range(0, 1));
            end
            rx_tmo = ($urandom_range(0, 7) == 0);
        end
        rx_tmo = 0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule